// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock Register Bank

This block keeps wall-clock time as seven byte-wide packed-BCD registers: seconds, minutes, hours, day of month, month, two-digit year and weekday. A sub-second prescaler counts strobes on a timebase input and moves the calendar forward by one second after every `TICKS_PER_SEC` strobes. The carries run from seconds up to the year, and the weekday steps with each new day. The month-length rules give November 31 days on purpose. Software that reads the clock must correct for that extra day.

Software reaches the bank through a byte-addressed port. The port takes one beat per cycle. A beat flagged as first takes its address from the bus, and each later beat uses the previous address plus one. A read burst starting at address 0x00 therefore returns all seven time fields in order. Those values come from a snapshot taken at the first beat, so a carry in the middle of the burst cannot tear the result. A control bit freezes the calendar while a new time is loaded. A sticky status bit, set by reset, records that the time has not yet been set.

Top module: `bcd_rtc_bank`

## Requirements
- R1: After reset the time fields read 00 s, 00 min, 00 h, day 01, month 01, year 00 and weekday 0. The control register reads 0x00 and the status register reads 0x80.
- R2: The time fields are packed BCD (high nibble tens, low nibble units) at addresses 0x00 seconds, 0x01 minutes, 0x02 hours, 0x03 day, 0x04 month, 0x05 year (last two digits after 2000) and 0x06 weekday. Control is at 0x10 with the stop flag in bit 0. Status is at 0x11 with the not-valid flag in bit 7. Every other bit and address reads 0x00, and writes to other addresses have no effect.
- R3: While running, the seconds field advances once for every `TICKS_PER_SEC` cycles in which `sec_tick` is high. Strobes are ignored while the clock is stopped. The sub-second count is zero when the clock restarts.
- R4: While control bit 0 is 1, the time fields hold their values. A field written while the clock is stopped reads back exactly the written byte.
- R5: Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry into the day.
- R6: Months 1, 3, 5, 7, 8, 10, 11 and 12 have 31 days, and months 4, 6 and 9 have 30. February has 29 days when the year is divisible by 4 (year 00 included) and 28 otherwise. Past the last day, the day becomes 01 and the month advances. Month 12 wraps to 01 and the year advances. Year 99 wraps to 00.
- R7: The weekday advances with every day carry and wraps from 6 to 0.
- R8: The status not-valid flag is set only by reset. Writing 1 to bit 7 of status clears it. Writing 0 to bit 7 leaves it unchanged.
- R9: A beat with `bus_first` high uses `bus_addr`. A beat with `bus_first` low uses the previous beat's address plus one.
- R10: In a burst, the first beat reads the live field. Each later beat reads the field's value as of the first beat, or the value written to it during the burst.
- R11: `bus_rdata` is 0x00 in every cycle with `bus_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle timebase strobe |
| bus_valid | input | 1 | A register access beat happens this cycle |
| bus_first | input | 1 | This beat starts a new burst at `bus_addr` |
| bus_write | input | 1 | 1 for a write beat, 0 for a read beat |
| bus_addr | input | 8 | Byte address, used when `bus_first` is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current beat, combinational |

## Verification
The assertions assume that software only ever writes legal BCD to the time fields: seconds and minutes up to 59, hours up to 23, day 01 to 31, month 01 to 12, and a weekday from 0 to 6. Under that assumption, the range and digit properties describe the counting logic alone. The stimulus writes only such values. It also changes time fields only while the stop bit is set, which is the loading procedure the control bit exists for. Each calendar corner is reached by loading the second before it and then giving exactly one second's worth of strobes.

// File: rtl/rtc_pkg.sv
// Package: shared field indices and BCD/calendar helper functions for the
// RTC register bank. Assumes fields are one byte of packed BCD each.
package rtc_pkg;

    localparam int FIELD_COUNT = 7;
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DAY   = 3;
    localparam int F_MONTH = 4;
    localparam int F_YEAR  = 5;
    localparam int F_WDAY  = 6;

    // Packed BCD byte to binary value.
    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    // Binary value (0..99) to packed BCD byte.
    function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v - (tens * 8'd10);
        return {tens[3:0], ones[3:0]};
    endfunction

    // Days in a month; November deliberately gets 31.
    function automatic logic [7:0] days_in_month(input logic [7:0] mon,
                                                 input logic [7:0] yr);
        case (mon)
            8'd2:                return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9:    return 8'd30;
            default:             return 8'd31;
        endcase
    endfunction

    // Lowest legal binary value of a field.
    function automatic logic [7:0] field_floor(input int idx);
        return (idx == F_DAY || idx == F_MONTH) ? 8'd1 : 8'd0;
    endfunction

    // Highest legal binary value of a field (day is replaced by month length).
    function automatic logic [7:0] field_ceiling(input int idx);
        case (idx)
            F_SEC, F_MIN: return 8'd59;
            F_HOUR:       return 8'd23;
            F_DAY:        return 8'd31;
            F_MONTH:      return 8'd12;
            F_YEAR:       return 8'd99;
            default:      return 8'd6;
        endcase
    endfunction

    // Reset value of a field, in BCD.
    function automatic logic [7:0] field_reset_bcd(input int idx);
        return (idx == F_DAY || idx == F_MONTH) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Module: sub-second prescaler. Counts timebase strobes and emits a one-cycle
// advance pulse every TICKS_PER_SEC strobes. Assumes the count must restart
// from zero whenever the clock is stopped.
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic adv
);

    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);
    assign adv     = run && tick && at_last;

    // Count strobes while running; hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_wrap_counter.sv
// Module: one BCD calendar field. Steps by one on inc, wraps from hi_bin
// back to lo_bin, and takes a written byte verbatim (write has priority).
// Assumes hi_bin/lo_bin are binary and the stored value is packed BCD.
module rtc_wrap_counter
    import rtc_pkg::*;
#(
    parameter logic [7:0] RST_BCD = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       wr_en,
    input  logic [7:0] wr_val,
    input  logic [7:0] lo_bin,
    input  logic [7:0] hi_bin,
    output logic [7:0] q
);

    logic [7:0] cur_bin;
    logic       at_top;

    assign cur_bin = bcd_to_bin(q);
    assign at_top  = (cur_bin >= hi_bin);

    // Load, step or wrap the field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_BCD;
        end else if (wr_en) begin
            q <= wr_val;
        end else if (inc) begin
            q <= at_top ? bin_to_bcd(lo_bin) : bin_to_bcd(cur_bin + 8'd1);
        end
    end

endmodule

// File: rtl/rtc_regport.sv
// Module: byte register port. Resolves the beat address (explicit or
// auto-incremented), decodes write strobes, keeps a burst snapshot of the
// time fields and muxes read data. Assumes one beat per cycle at most.
module rtc_regport
    import rtc_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_valid,
    input  logic                        bus_first,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [7:0]                  bus_wdata,
    input  logic [FIELD_COUNT-1:0][7:0] live,
    input  logic                        stop_q,
    input  logic                        flag_q,
    output logic [FIELD_COUNT-1:0]      field_wr,
    output logic                        ctrl_wr,
    output logic                        stat_wr,
    output logic [7:0]                  bus_rdata
);

    localparam int FW = $clog2(FIELD_COUNT);
    localparam logic [ADDR_W-1:0] FIELDS_A = ADDR_W'(FIELD_COUNT);

    logic [ADDR_W-1:0]           ptr_q;
    logic [ADDR_W-1:0]           eff;
    logic [FIELD_COUNT-1:0][7:0] shadow_q;
    logic                        beat_wr;
    logic                        in_time;

    assign eff     = bus_first ? bus_addr : ptr_q;
    assign beat_wr = bus_valid && bus_write;
    assign in_time = (eff < FIELDS_A);
    assign ctrl_wr = beat_wr && (eff == CTRL_ADDR);
    assign stat_wr = beat_wr && (eff == STAT_ADDR);

    generate
        for (genvar i = 0; i < FIELD_COUNT; i++) begin : g_dec
            assign field_wr[i] = beat_wr && (eff == ADDR_W'(i));

            // Snapshot on a burst start; follow writes made inside the burst.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shadow_q[i] <= field_reset_bcd(i);
                end else if (field_wr[i]) begin
                    shadow_q[i] <= bus_wdata;
                end else if (bus_valid && bus_first) begin
                    shadow_q[i] <= live[i];
                end
            end
        end
    endgenerate

    // Remember the address the next beat of a burst will use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (bus_valid) begin
            ptr_q <= eff + ADDR_W'(1);
        end
    end

    // Select the read byte for the current beat.
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_valid) begin
            if (in_time) begin
                bus_rdata = bus_first ? live[eff[FW-1:0]] : shadow_q[eff[FW-1:0]];
            end else if (eff == CTRL_ADDR) begin
                bus_rdata = {7'd0, stop_q};
            end else if (eff == STAT_ADDR) begin
                bus_rdata = {flag_q, 7'd0};
            end
        end
    end

endmodule

// File: rtl/bcd_rtc_bank.sv
// Module: top of the BCD calendar RTC register bank. Holds the stop bit and
// the sticky not-valid flag, chains the seven field counters and connects
// the register port. Assumes sec_tick is a one-cycle strobe in clk domain.
module bcd_rtc_bank
    import rtc_pkg::*;
#(
    parameter int                TICKS_PER_SEC = 4,
    parameter int                ADDR_W        = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR     = 8'h10,
    parameter logic [ADDR_W-1:0] STAT_ADDR     = 8'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_valid,
    input  logic              bus_first,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);

    logic [FIELD_COUNT-1:0][7:0] time_q;
    logic [FIELD_COUNT-1:0][7:0] field_hi;
    logic [FIELD_COUNT-1:0]      field_inc;
    logic [FIELD_COUNT-1:0]      field_wr;
    logic [F_MONTH:0]            field_carry;
    logic                        ctrl_wr;
    logic                        stat_wr;
    logic                        stop_q;
    logic                        flag_q;
    logic                        sec_adv;

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!stop_q),
        .tick  (sec_tick),
        .adv   (sec_adv)
    );

    rtc_regport #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_first (bus_first),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .live      (time_q),
        .stop_q    (stop_q),
        .flag_q    (flag_q),
        .field_wr  (field_wr),
        .ctrl_wr   (ctrl_wr),
        .stat_wr   (stat_wr),
        .bus_rdata (bus_rdata)
    );

    // Field ceilings; the day ceiling follows the current month and year.
    always_comb begin
        for (int i = 0; i < FIELD_COUNT; i++) begin
            field_hi[i] = field_ceiling(i);
        end
        field_hi[F_DAY] = days_in_month(bcd_to_bin(time_q[F_MONTH]),
                                        bcd_to_bin(time_q[F_YEAR]));
    end

    // Carry chain: seconds -> minutes -> hours -> day/weekday -> month -> year.
    always_comb begin
        field_inc[F_SEC] = sec_adv;
        for (int i = F_SEC; i <= F_MONTH; i++) begin
            field_carry[i] = field_inc[i] && (bcd_to_bin(time_q[i]) >= field_hi[i]);
            if (i < F_MONTH) begin
                field_inc[i+1] = field_carry[i];
            end
        end
        field_inc[F_YEAR] = field_carry[F_MONTH];
        field_inc[F_WDAY] = field_carry[F_HOUR];
    end

    generate
        for (genvar i = 0; i < FIELD_COUNT; i++) begin : g_field
            rtc_wrap_counter #(.RST_BCD(field_reset_bcd(i))) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .inc    (field_inc[i]),
                .wr_en  (field_wr[i]),
                .wr_val (bus_wdata),
                .lo_bin (field_floor(i)),
                .hi_bin (field_hi[i]),
                .q      (time_q[i])
            );
        end
    endgenerate

    // Stop bit: loaded from control bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
        end else if (ctrl_wr) begin
            stop_q <= bus_wdata[0];
        end
    end

    // Not-valid flag: set by reset, cleared by writing 1 to status bit 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b1;
        end else if (stat_wr && bus_wdata[7]) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_bank_checker.sv
// Module: property checker for bcd_rtc_bank, attached by bind. Assumes
// software writes only legal BCD values into the time fields.
module rtc_bank_checker (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_valid,
    input logic            bus_write,
    input logic [7:0]      bus_rdata,
    input logic            stop_q,
    input logic            flag_q,
    input logic [6:0][7:0] time_q
);

    // True when every field's units nibble is a decimal digit.
    function automatic logic digits_ok(input logic [6:0][7:0] t);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 7; i++) begin
            if (t[i][3:0] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> bus_rdata == 8'h00);

    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !(bus_valid && bus_write)) |=> $stable(time_q));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_q |=> !flag_q);

    p_sec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (time_q[0] <= 8'h59 && time_q[1] <= 8'h59 && time_q[2] <= 8'h23));

    p_day_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (time_q[3] != 8'h00 && time_q[4] != 8'h00 && time_q[4] <= 8'h12));

    p_wday_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> time_q[6] <= 8'h06);

    p_bcd_digits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> digits_ok(time_q));

endmodule

bind bcd_rtc_bank rtc_bank_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_rdata (bus_rdata),
    .stop_q    (stop_q),
    .flag_q    (flag_q),
    .time_q    (time_q)
);

// File: tb/tb_bcd_rtc_bank.sv
module tb_bcd_rtc_bank;

    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       bus_valid = 1'b0;
    logic       bus_first = 1'b0;
    logic       bus_write = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    always #4 clk = ~clk;

    bcd_rtc_bank #(.TICKS_PER_SEC(N)) dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_valid(bus_valid),
        .bus_first(bus_first), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // Behavioural reference state.
    logic [7:0] m_t[7];
    logic [7:0] m_snap[7];
    int         m_sub;
    logic       m_stop;
    logic       m_flag;
    logic [7:0] m_ptr;

    function automatic int b2i(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] m_expect(logic v, logic f, logic [7:0] a);
        logic [7:0] e;
        e = f ? a : m_ptr;
        if (!v) return 8'h00;
        if (e < 8'd7) return f ? m_t[e] : m_snap[e];
        if (e == 8'h10) return {7'd0, m_stop};
        if (e == 8'h11) return {m_flag, 7'd0};
        return 8'h00;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 7; i++) begin
            m_t[i] = (i == 3 || i == 4) ? 8'h01 : 8'h00;
            m_snap[i] = m_t[i];
        end
        m_sub = 0; m_stop = 1'b0; m_flag = 1'b1; m_ptr = 8'h00;
    endtask

    task automatic m_step(logic v, logic f, logic w, logic [7:0] a, logic [7:0] d, logic t);
        logic [7:0] nt[7];
        logic [7:0] e;
        bit adv;
        for (int i = 0; i < 7; i++) nt[i] = m_t[i];
        adv = !m_stop && t && (m_sub == N - 1);
        if (m_stop) m_sub = 0;
        else if (t) m_sub = (m_sub == N - 1) ? 0 : m_sub + 1;
        if (adv) begin
            nt[0] = (b2i(m_t[0]) >= 59) ? 8'h00 : i2b(b2i(m_t[0]) + 1);
            if (b2i(m_t[0]) >= 59) begin
                nt[1] = (b2i(m_t[1]) >= 59) ? 8'h00 : i2b(b2i(m_t[1]) + 1);
                if (b2i(m_t[1]) >= 59) begin
                    nt[2] = (b2i(m_t[2]) >= 23) ? 8'h00 : i2b(b2i(m_t[2]) + 1);
                    if (b2i(m_t[2]) >= 23) begin
                        nt[6] = (b2i(m_t[6]) >= 6) ? 8'h00 : i2b(b2i(m_t[6]) + 1);
                        if (b2i(m_t[3]) >= mdays(b2i(m_t[4]), b2i(m_t[5]))) begin
                            nt[3] = 8'h01;
                            nt[4] = (b2i(m_t[4]) >= 12) ? 8'h01 : i2b(b2i(m_t[4]) + 1);
                            if (b2i(m_t[4]) >= 12)
                                nt[5] = (b2i(m_t[5]) >= 99) ? 8'h00 : i2b(b2i(m_t[5]) + 1);
                        end else begin
                            nt[3] = i2b(b2i(m_t[3]) + 1);
                        end
                    end
                end
            end
        end
        if (v) begin
            e = f ? a : m_ptr;
            if (f) for (int i = 0; i < 7; i++) m_snap[i] = m_t[i];
            if (w) begin
                if (e < 8'd7) begin nt[e] = d; m_snap[e] = d; end
                if (e == 8'h10) m_stop = d[0];
                if (e == 8'h11 && d[7]) m_flag = 1'b0;
            end
            m_ptr = e + 8'd1;
        end
        for (int i = 0; i < 7; i++) m_t[i] = nt[i];
    endtask

    task automatic check(logic [7:0] got, logic [7:0] exp, string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One clock: drive, compare with model (and an explicit value), advance.
    task automatic cyc(logic v, logic f, logic w, logic [7:0] a, logic [7:0] d, logic t,
                       bit xchk = 1'b0, logic [7:0] xexp = 8'h00, string xtag = "");
        bus_valid = v; bus_first = f; bus_write = w; bus_addr = a; bus_wdata = d; sec_tick = t;
        #1;
        check(bus_rdata, m_expect(v, f, a), phase);
        if (xchk) check(bus_rdata, xexp, xtag);
        @(posedge clk);
        m_step(v, f, w, a, d, t);
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        cyc(1'b1, 1'b1, 1'b1, a, d, 1'b0);
    endtask

    task automatic rd(logic [7:0] a, logic f, logic [7:0] exp, string tag);
        cyc(1'b1, f, 1'b0, a, 8'h00, 1'b0, 1'b1, exp, tag);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
    endtask

    task automatic load_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dy,
                             logic [7:0] mo, logic [7:0] yr, logic [7:0] wd);
        wr(8'h10, 8'h01);
        cyc(1'b1, 1'b1, 1'b1, 8'h00, s, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 8'h00, mi, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 8'h00, h, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 8'h00, dy, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 8'h00, mo, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 8'h00, yr, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 8'h00, wd, 1'b0);
        wr(8'h10, 8'h00);
    endtask

    task automatic expect_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dy,
                               logic [7:0] mo, logic [7:0] yr, logic [7:0] wd, string tag);
        rd(8'h00, 1'b1, s, tag);
        rd(8'h00, 1'b0, mi, tag);
        rd(8'h00, 1'b0, h, tag);
        rd(8'h00, 1'b0, dy, tag);
        rd(8'h00, 1'b0, mo, tag);
        rd(8'h00, 1'b0, yr, tag);
        rd(8'h00, 1'b0, wd, tag);
    endtask

    // Load the second before a corner, give one second of strobes, read back.
    task automatic roll(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dy,
                        logic [7:0] mo, logic [7:0] yr, logic [7:0] wd,
                        logic [7:0] es, logic [7:0] emi, logic [7:0] eh, logic [7:0] edy,
                        logic [7:0] emo, logic [7:0] eyr, logic [7:0] ewd, string tag);
        load_time(s, mi, h, dy, mo, yr, wd);
        ticks(N);
        expect_time(es, emi, eh, edy, emo, eyr, ewd, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        phase = "R1";
        expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, "R1 reset time");
        rd(8'h10, 1'b1, 8'h00, "R1 reset control");
        rd(8'h11, 1'b1, 8'h80, "R1 reset status");

        phase = "R9";
        rd(8'h10, 1'b1, 8'h00, "R9 burst first beat at control");
        rd(8'h00, 1'b0, 8'h80, "R9 burst second beat reaches status");

        phase = "R11";
        cyc(1'b0, 1'b0, 1'b0, 8'h11, 8'h00, 1'b0, 1'b1, 8'h00, "R11 idle rdata");
        cyc(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, "R11 idle rdata with first");

        phase = "R2";
        wr(8'h07, 8'h55);
        wr(8'h20, 8'h99);
        rd(8'h07, 1'b1, 8'h00, "R2 unmapped reads zero");
        expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, "R2 unmapped write ignored");

        phase = "R3";
        ticks(N - 1);
        rd(8'h00, 1'b1, 8'h00, "R3 no advance before N strobes");
        ticks(1);
        rd(8'h00, 1'b1, 8'h01, "R3 advance on Nth strobe");
        wr(8'h10, 8'h01);
        ticks(2 * N);
        rd(8'h00, 1'b1, 8'h01, "R3 strobes ignored while stopped");
        wr(8'h10, 8'h00);
        ticks(2);
        wr(8'h10, 8'h01);
        wr(8'h10, 8'h00);
        ticks(N - 1);
        rd(8'h00, 1'b1, 8'h01, "R3 sub-second count cleared on restart");
        ticks(1);
        rd(8'h00, 1'b1, 8'h02, "R3 advance after restart");

        phase = "R4";
        wr(8'h10, 8'h01);
        wr(8'h02, 8'h17);
        wr(8'h06, 8'h05);
        ticks(N);
        rd(8'h02, 1'b1, 8'h17, "R4 written hour held while stopped");
        rd(8'h06, 1'b1, 8'h05, "R4 written weekday held while stopped");
        rd(8'h10, 1'b1, 8'h01, "R4 stop bit reads back");
        wr(8'h10, 8'h00);

        phase = "R5";
        roll(8'h59, 8'h59, 8'h12, 8'h15, 8'h06, 8'h10, 8'h02,
             8'h00, 8'h00, 8'h13, 8'h15, 8'h06, 8'h10, 8'h02, "R5 hour carry");
        roll(8'h59, 8'h59, 8'h23, 8'h15, 8'h06, 8'h10, 8'h02,
             8'h00, 8'h00, 8'h00, 8'h16, 8'h06, 8'h10, 8'h03, "R5 midnight R7");

        phase = "R6";
        roll(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h06,
             8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, "R6 year wrap R7");
        roll(8'h59, 8'h59, 8'h23, 8'h30, 8'h11, 8'h21, 8'h01,
             8'h00, 8'h00, 8'h00, 8'h31, 8'h11, 8'h21, 8'h02, "R6 november 31");
        roll(8'h59, 8'h59, 8'h23, 8'h31, 8'h11, 8'h21, 8'h02,
             8'h00, 8'h00, 8'h00, 8'h01, 8'h12, 8'h21, 8'h03, "R6 november to december");
        roll(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h03,
             8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24, 8'h04, "R6 leap february 29");
        roll(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 8'h04,
             8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h24, 8'h05, "R6 leap february end");
        roll(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h05,
             8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23, 8'h06, "R6 common february end");
        roll(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00, 8'h06,
             8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h00, 8'h00, "R6 year 00 leap R7 wrap");
        roll(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h19, 8'h00,
             8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h19, 8'h01, "R6 april end");

        phase = "R8";
        rd(8'h11, 1'b1, 8'h80, "R8 flag still set");
        wr(8'h11, 8'h7f);
        rd(8'h11, 1'b1, 8'h80, "R8 writing 0 to bit 7 keeps flag");
        wr(8'h11, 8'h80);
        rd(8'h11, 1'b1, 8'h00, "R8 writing 1 clears flag");
        wr(8'h11, 8'h00);
        ticks(N);
        rd(8'h11, 1'b1, 8'h00, "R8 flag stays clear");

        phase = "R10";
        load_time(8'h59, 8'h10, 8'h08, 8'h05, 8'h07, 8'h30, 8'h01);
        ticks(N - 1);
        cyc(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 8'h59, "R10 first beat live seconds");
        rd(8'h00, 1'b0, 8'h10, "R10 later beat reads snapshot minutes");
        rd(8'h00, 1'b0, 8'h08, "R10 later beat reads snapshot hours");
        rd(8'h01, 1'b1, 8'h11, "R10 fresh read sees carried minutes");
        rd(8'h00, 1'b1, 8'h00, "R10 fresh read sees wrapped seconds");

        phase = "R11";
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, "R11 idle after traffic");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule